// File: doc/BRIEF.md
# Strobed Byte Input Port

This block receives one byte at a time from a peripheral and hands it to a CPU bus. The peripheral places a byte on its data lines and pulses an active-low strobe. The port brings the strobe into the system clock domain and detects its falling edge. On that edge it captures the byte and raises a buffer-full flag, which tells the peripheral that the byte has been accepted.

The CPU reads the byte through a chip-select and a read enable. A data read returns the captured byte in the same cycle and drops buffer-full on the next clock edge, which lets the peripheral send the next byte. A strobe that arrives while the buffer is still full does not replace the held byte. It sets a sticky overrun bit instead. A status location reports the flag, the overrun bit and the interrupt enable. When the enable is set, an interrupt request follows buffer-full.

Top module: `strobed_in_port`

## Requirements
- R1: After reset, full_o and irq_o are 0, the data location reads 0 and the status location reads 0.
- R2: A falling edge on stb_ni captures data_i into the data register. full_o is 1 from the third rising clock edge after the first edge that samples stb_ni low.
- R3: full_o stays 1 through any number of idle cycles and status reads. It falls only on the clock edge that ends a data read.
- R4: A data read is one cycle with cs_i=1, rd_i=1 and addr_i=0. In that cycle rdata_o shows the captured byte.
- R5: A strobe falling edge while full_o is 1 leaves the data register unchanged and sets overrun (status bit 1).
- R6: A data read clears the overrun bit on the edge that ends the read.
- R7: One strobe pulse loads one byte. A strobe held low after the data read does not set full_o again.
- R8: A status read (cs_i=1, rd_i=1, addr_i=1) returns bit 0 = full, bit 1 = overrun, bit 2 = interrupt enable and zeros above. It changes no state.
- R9: A write (cs_i=1, wr_i=1, addr_i=1) loads ie_wdata_i into the interrupt enable. irq_o equals full_o AND the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Peripheral data bus |
| stb_ni | input | 1 | Peripheral strobe, active low, asynchronous |
| full_o | output | 1 | Buffer-full handshake to the peripheral |
| cs_i | input | 1 | CPU chip select |
| rd_i | input | 1 | CPU read enable |
| wr_i | input | 1 | CPU write enable |
| addr_i | input | 1 | 0 = data location, 1 = status/control location |
| ie_wdata_i | input | 1 | Interrupt enable value for a control write |
| rdata_o | output | 8 | CPU read data, valid in the read cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the handshake order. If full_o dropped on a status read or by itself, the flag would be low at a check where it must still be 1. It holds the strobe low across a data read. A design that triggered on the strobe level rather than its edge would set full again. It sends a second byte into a full buffer. A design that overwrote the register would return the new byte, and one without the sticky bit would show a zero overrun bit in the status. It also checks that the interrupt request is off while the enable is clear and that it follows the flag once the enable is set.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned STAT_W = 3;

  typedef struct packed {
    logic ie;
    logic ovr;
    logic full;
  } stat_t;
endpackage

// File: rtl/sip_stb_sync.sv
module sip_stb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_ni,
  output logic fall_o
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[LEN-2:0], stb_ni};
  end

  // high->low between the last sync stage and the edge flop
  assign fall_o = sh_q[LEN-1] & ~sh_q[LEN-2];
endmodule

// File: rtl/sip_data_reg.sv
module sip_data_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/sip_flag_ctrl.sv
module sip_flag_ctrl
  import sip_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fall_i,
  input  logic  dread_i,
  input  logic  ctl_wr_i,
  input  logic  ie_d_i,
  output logic  load_o,
  output stat_t stat_o
);
  stat_t st_q;

  // a read in the same cycle frees the slot for the new byte
  assign load_o = fall_i & (~st_q.full | dread_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      if (load_o)       st_q.full <= 1'b1;
      else if (dread_i) st_q.full <= 1'b0;

      if (fall_i && st_q.full && !dread_i) st_q.ovr <= 1'b1;
      else if (dread_i)                    st_q.ovr <= 1'b0;

      if (ctl_wr_i) st_q.ie <= ie_d_i;
    end
  end

  assign stat_o = st_q;
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
  import sip_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stb_ni,
  output logic              full_o,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic              ie_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              fall;
  logic              load;
  logic              dread;
  logic              sread;
  logic              ctl_wr;
  logic [DATA_W-1:0] data_q;
  stat_t             stat;

  assign dread  = cs_i & rd_i & ~addr_i;
  assign sread  = cs_i & rd_i & addr_i;
  assign ctl_wr = cs_i & wr_i & addr_i;

  sip_stb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_ni (stb_ni),
    .fall_o (fall)
  );

  sip_data_reg #(.W(DATA_W)) u_dreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (data_i),
    .q_o    (data_q)
  );

  sip_flag_ctrl u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .dread_i  (dread),
    .ctl_wr_i (ctl_wr),
    .ie_d_i   (ie_wdata_i),
    .load_o   (load),
    .stat_o   (stat)
  );

  always_comb begin
    rdata_o = '0;
    if (dread)      rdata_o = data_q;
    else if (sread) rdata_o[STAT_W-1:0] = stat;
  end

  assign full_o = stat.full;
  assign irq_o  = stat.ie & stat.full;
endmodule

// File: rtl/strobed_in_port_chk.sv
module strobed_in_port_chk
  import sip_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              full_o,
  input logic              irq_o,
  input logic              fall,
  input logic              dread,
  input logic [DATA_W-1:0] data_q,
  input stat_t             stat
);
  // R2
  full_rise_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(fall));
  // R3
  full_fall_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(dread));
  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !dread) |=> $stable(data_q));
  // R5
  ovr_only_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat.ovr) |-> $past(full_o));
  // R6
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dread |=> !stat.ovr);
  // R9
  irq_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_o);
endmodule

bind strobed_in_port strobed_in_port_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .full_o (full_o),
  .irq_o  (irq_o),
  .fall   (fall),
  .dread  (dread),
  .data_q (data_q),
  .stat   (stat)
);

// File: tb/strobed_in_port_test.sv
module strobed_in_port_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       stb_ni = 1'b1;
  logic       full_o;
  logic       cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, addr_i = 1'b0, ie_wdata_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  strobed_in_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .stb_ni(stb_ni), .full_o(full_o),
    .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .ie_wdata_i(ie_wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe low with byte, full expected after 3 edges; strobe released after
  task automatic strobe(input logic [7:0] b, input bit release_it);
    @(negedge clk);
    data_i = b; stb_ni = 1'b0;
    idle(3);
    if (release_it) begin
      idle(1); stb_ni = 1'b1;
      idle(3);
    end
  endtask

  task automatic cpu_read(input logic a, input string req, input logic [7:0] exp);
    @(negedge clk);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    #1 check(req, rdata_o, exp);
    @(negedge clk);
    cs_i = 1'b0; rd_i = 1'b0; addr_i = 1'b0;
  endtask

  task automatic cpu_write_ie(input logic v);
    @(negedge clk);
    cs_i = 1'b1; wr_i = 1'b1; addr_i = 1'b1; ie_wdata_i = v;
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0; addr_i = 1'b0; ie_wdata_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 full", {7'b0, full_o}, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    cpu_read(1'b0, "R1 data", 8'h00);
    cpu_read(1'b1, "R1 status", 8'h00);
  endtask

  task automatic t_basic;
    @(negedge clk);
    data_i = 8'hA5; stb_ni = 1'b0;
    idle(2);
    check("R2 full not yet", {7'b0, full_o}, 8'h00);
    idle(1);
    check("R2 full latency", {7'b0, full_o}, 8'h01);
    idle(1); stb_ni = 1'b1; data_i = 8'h00;
    idle(10);
    check("R3 full held", {7'b0, full_o}, 8'h01);
    cpu_read(1'b1, "R8 status full", 8'h01);
    check("R8 status no side effect", {7'b0, full_o}, 8'h01);
    cpu_read(1'b0, "R4 data", 8'hA5);
    check("R3 full cleared", {7'b0, full_o}, 8'h00);
  endtask

  task automatic t_overrun;
    strobe(8'h3C, 1'b1);
    strobe(8'hC3, 1'b1);
    check("R5 still full", {7'b0, full_o}, 8'h01);
    cpu_read(1'b1, "R5 overrun set", 8'h03);
    cpu_read(1'b0, "R5 data kept", 8'h3C);
    cpu_read(1'b1, "R6 overrun cleared", 8'h00);
  endtask

  task automatic t_level;
    strobe(8'h5A, 1'b0);
    cpu_read(1'b0, "R7 data", 8'h5A);
    idle(8);
    check("R7 no retrigger", {7'b0, full_o}, 8'h00);
    stb_ni = 1'b1;
    idle(4);
    strobe(8'h77, 1'b1);
    cpu_read(1'b0, "R7 next byte", 8'h77);
  endtask

  task automatic t_irq;
    strobe(8'h11, 1'b1);
    check("R9 irq off when disabled", {7'b0, irq_o}, 8'h00);
    cpu_write_ie(1'b1);
    check("R9 irq on", {7'b0, irq_o}, 8'h01);
    cpu_read(1'b1, "R8 status ie+full", 8'h05);
    cpu_read(1'b0, "R9 data", 8'h11);
    check("R9 irq drops", {7'b0, irq_o}, 8'h00);
    cpu_write_ie(1'b0);
    cpu_read(1'b1, "R9 ie cleared", 8'h00);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_basic();
    t_overrun();
    t_level();
    t_irq();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule